// File: doc/BRIEF.md
# Software Interrupt Delivery Filter

This block sits between the source of software-generated interrupt requests and the per-core pending state of the local interrupt controller. Each request names a target interrupt, numbered 0 to 15, and carries a requested group and a flag saying whether it comes from non-secure state. Alongside each request, a neighbouring block supplies the target's resolved group, its 2-bit non-secure access field, and the global security-disable level. The filter decides whether the request may mark the target pending.

An accepted request produces a one-cycle pulse together with the target number. The pending store sets the bit, and the priority arbiter re-evaluates the highest-priority pending interrupt on that pulse. Requests that fail the group or access rules are dropped without any output. A target number outside the implemented range raises a one-cycle error pulse instead. The request side uses a valid/ready handshake and takes at most one request per clock.

Group codes on `req_grp_i` and `tgt_grp_i`:
- 0: group 0
- 1: secure group 1
- 2: non-secure group 1
- 3: reserved

Top module: `sgi_filter`

## Requirements
- R1: While `rst_ni` is low, `set_pend_o` and `id_err_o` are 0. `req_ready_o` is 0 during reset, becomes 1 at the first clock edge after reset is released, and then stays 1.
- R2: A request is taken on a rising edge where `req_valid_i` and `req_ready_o` are both 1. If it is accepted, `set_pend_o` is 1 for exactly the following cycle, and `set_id_o` holds the request number during that cycle. With no handshake, no pulse appears.
- R3: A request for secure group 1 (code 1) whose target has resolved group 0 (code 0) is handled as a group 0 request. If the access rules permit, it is accepted.
- R4: A request whose effective group is group 0 is dropped when the target's resolved group is not 0. A request or target group of code 3 always drops the request.
- R5: With `sec_dis_i`=0 and `req_ns_i`=1, a request to a group 0 target is dropped when `tgt_acc_i` is 0, and passes this check when `tgt_acc_i` is 1 or more.
- R6: With `sec_dis_i`=0 and `req_ns_i`=1, a request to a secure group 1 target is dropped when `tgt_acc_i` is below 2, and passes this check when it is 2 or 3.
- R7: With `sec_dis_i`=1, `tgt_acc_i` has no effect on acceptance.
- R8: A request numbered 16 or above never produces `set_pend_o`. It produces `id_err_o` for exactly the cycle after its handshake. `id_err_o` and `set_pend_o` are never 1 together.
- R9: A request from secure state (`req_ns_i`=0), or a request to a non-secure group 1 target (code 2), is accepted regardless of `tgt_acc_i` once the group rules pass.
- R10: Requests on consecutive cycles are each judged on their own inputs. Each one yields its own pulse in the cycle after its handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Filter can take a request |
| req_id_i | input | ID_W (5) | Target interrupt number |
| req_grp_i | input | 2 | Requested group code |
| req_ns_i | input | 1 | Request comes from non-secure state |
| sec_dis_i | input | 1 | Security disabled globally |
| tgt_grp_i | input | 2 | Resolved group code of the target |
| tgt_acc_i | input | 2 | Non-secure access field of the target |
| set_pend_o | output | 1 | One-cycle pulse: set target pending and re-evaluate |
| set_id_o | output | ID_W (5) | Interrupt number to mark pending |
| id_err_o | output | 1 | One-cycle pulse: request number out of range |

## Verification
The subtle case is the interaction between the group downgrade and the access thresholds. A secure group 1 request to a group 0 target from non-secure state must be judged against the group 0 threshold, not the group 1 one. It must also still be dropped when the access field is 0. The bench sweeps every combination of requested group, target group, origin, security-disable level and access value through one table-driven task. It compares each outcome against an independent model. It also runs back-to-back requests with alternating outcomes, to show that decisions do not leak from one cycle into the next.

// File: rtl/sgi_filter_pkg.sv
package sgi_filter_pkg;
  typedef enum logic [1:0] {
    GRP_0   = 2'd0,
    GRP_1S  = 2'd1,
    GRP_1NS = 2'd2,
    GRP_RSV = 2'd3
  } sgi_grp_e;
endpackage

// File: rtl/sgi_grp_match.sv
module sgi_grp_match
  import sgi_filter_pkg::*;
(
  input  logic [1:0] req_grp_i,
  input  logic [1:0] tgt_grp_i,
  output logic       grp_ok_o
);
  sgi_grp_e req_g, tgt_g, eff_g;

  always_comb begin
    req_g = sgi_grp_e'(req_grp_i);
    tgt_g = sgi_grp_e'(tgt_grp_i);
    // secure group 1 request on a group 0 target degrades to group 0
    eff_g = (req_g == GRP_1S && tgt_g == GRP_0) ? GRP_0 : req_g;
    grp_ok_o = 1'b1;
    if (req_g == GRP_RSV || tgt_g == GRP_RSV) grp_ok_o = 1'b0;
    else if (eff_g == GRP_0 && tgt_g != GRP_0) grp_ok_o = 1'b0;
  end
endmodule

// File: rtl/sgi_ns_gate.sv
module sgi_ns_gate
  import sgi_filter_pkg::*;
#(
  parameter int ACC_W   = 2,
  parameter int G0_MIN  = 1,
  parameter int G1S_MIN = 2
) (
  input  logic             ns_i,
  input  logic             sec_dis_i,
  input  logic [1:0]       tgt_grp_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic             ns_ok_o
);
  localparam logic [ACC_W-1:0] G0_THR  = ACC_W'(G0_MIN);
  localparam logic [ACC_W-1:0] G1S_THR = ACC_W'(G1S_MIN);

  sgi_grp_e tgt_g;

  always_comb begin
    tgt_g   = sgi_grp_e'(tgt_grp_i);
    ns_ok_o = 1'b1;
    if (ns_i && !sec_dis_i) begin
      if (tgt_g == GRP_0 && acc_i < G0_THR) ns_ok_o = 1'b0;
      if (tgt_g == GRP_1S && acc_i < G1S_THR) ns_ok_o = 1'b0;
    end
  end
endmodule

// File: rtl/sgi_filter.sv
module sgi_filter #(
  parameter int ID_W    = 5,
  parameter int NUM_SGI = 16,
  parameter int ACC_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [ID_W-1:0]  req_id_i,
  input  logic [1:0]       req_grp_i,
  input  logic             req_ns_i,
  input  logic             sec_dis_i,
  input  logic [1:0]       tgt_grp_i,
  input  logic [ACC_W-1:0] tgt_acc_i,
  output logic             set_pend_o,
  output logic [ID_W-1:0]  set_id_o,
  output logic             id_err_o
);
  localparam int ID_SPAN = 1 << ID_W;

  logic rdy_q, hs, in_range, grp_ok, ns_ok, accept;
  logic set_q, err_q;
  logic [ID_W-1:0] id_q;

  generate
    if (NUM_SGI >= ID_SPAN) begin : g_full_range
      assign in_range = 1'b1;
    end else begin : g_part_range
      assign in_range = req_id_i < ID_W'(NUM_SGI);
    end
  endgenerate

  sgi_grp_match u_grp (
    .req_grp_i (req_grp_i),
    .tgt_grp_i (tgt_grp_i),
    .grp_ok_o  (grp_ok)
  );

  sgi_ns_gate #(.ACC_W(ACC_W)) u_ns (
    .ns_i      (req_ns_i),
    .sec_dis_i (sec_dis_i),
    .tgt_grp_i (tgt_grp_i),
    .acc_i     (tgt_acc_i),
    .ns_ok_o   (ns_ok)
  );

  assign hs     = req_valid_i && rdy_q;
  assign accept = hs && in_range && grp_ok && ns_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      set_q <= 1'b0;
      err_q <= 1'b0;
      id_q  <= '0;
    end else begin
      rdy_q <= 1'b1;
      set_q <= accept;
      err_q <= hs && !in_range;
      if (accept) id_q <= req_id_i;
    end
  end

  assign req_ready_o = rdy_q;
  assign set_pend_o  = set_q;
  assign set_id_o    = id_q;
  assign id_err_o    = err_q;
endmodule

// File: rtl/sgi_filter_chk.sv
module sgi_filter_chk #(
  parameter int ID_W    = 5,
  parameter int NUM_SGI = 16,
  parameter int ACC_W   = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [ID_W-1:0]  req_id_i,
  input logic [1:0]       req_grp_i,
  input logic             req_ns_i,
  input logic             sec_dis_i,
  input logic [1:0]       tgt_grp_i,
  input logic [ACC_W-1:0] tgt_acc_i,
  input logic             set_pend_o,
  input logic [ID_W-1:0]  set_id_o,
  input logic             id_err_o
);
  p_ready_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> req_ready_o);

  p_set_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_pend_o |-> ($past(req_valid_i && req_ready_o) && set_id_o == $past(req_id_i)));

  p_drop_grp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_grp_i == 2'd0 && tgt_grp_i != 2'd0) |=> !set_pend_o);

  p_ns_g0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_ns_i && !sec_dis_i && tgt_grp_i == 2'd0
     && tgt_acc_i == '0) |=> !set_pend_o);

  p_ns_g1s_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_ns_i && !sec_dis_i && tgt_grp_i == 2'd1
     && int'(tgt_acc_i) < 2) |=> !set_pend_o);

  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_pend_o && id_err_o));

  p_err_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_err_o |-> $past(req_valid_i && req_ready_o && int'(req_id_i) >= NUM_SGI));

  p_set_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_pend_o |-> int'(set_id_o) < NUM_SGI);
endmodule

bind sgi_filter sgi_filter_chk #(.ID_W(ID_W), .NUM_SGI(NUM_SGI), .ACC_W(ACC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_id_i(req_id_i), .req_grp_i(req_grp_i), .req_ns_i(req_ns_i), .sec_dis_i(sec_dis_i),
  .tgt_grp_i(tgt_grp_i), .tgt_acc_i(tgt_acc_i), .set_pend_o(set_pend_o),
  .set_id_o(set_id_o), .id_err_o(id_err_o)
);

// File: tb/sgi_filter_test.sv
module sgi_filter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic       ready;
  logic [4:0] id = '0;
  logic [1:0] rgrp = '0;
  logic       ns = 1'b0;
  logic       sdis = 1'b0;
  logic [1:0] tgrp = '0;
  logic [1:0] acc = '0;
  logic       setp;
  logic [4:0] sid;
  logic       err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgi_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_id_i(id), .req_grp_i(rgrp), .req_ns_i(ns), .sec_dis_i(sdis),
    .tgt_grp_i(tgrp), .tgt_acc_i(acc), .set_pend_o(setp), .set_id_o(sid),
    .id_err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit model(input int i, input int rg, input bit n, input bit sd,
                               input int tg, input int a);
    int eff;
    if (i >= 16) return 1'b0;
    if (rg == 3 || tg == 3) return 1'b0;
    eff = (rg == 1 && tg == 0) ? 0 : rg;
    if (eff == 0 && tg != 0) return 1'b0;
    if (n && !sd) begin
      if (tg == 0 && a < 1) return 1'b0;
      if (tg == 1 && a < 2) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic drive(input int i, input int rg, input bit n, input bit sd,
                       input int tg, input int a);
    valid = 1'b1; id = 5'(i); rgrp = 2'(rg); ns = n; sdis = sd; tgrp = 2'(tg); acc = 2'(a);
  endtask

  // one request; result sampled at the negedge after the handshake edge
  task automatic send(input string req, input int i, input int rg, input bit n,
                      input bit sd, input int tg, input int a);
    bit e;
    e = model(i, rg, n, sd, tg, a);
    @(negedge clk);
    drive(i, rg, n, sd, tg, a);
    @(negedge clk);
    valid = 1'b0;
    chk(req, setp, e);
    if (e) chk(req, sid, i);
    chk({req, " err"}, err, (i >= 16) ? 1 : 0);
    @(negedge clk);
    chk({req, " pulse width"}, setp, 0);
  endtask

  task automatic t_reset;
    chk("R1 set in reset", setp, 0);
    chk("R1 err in reset", err, 0);
    chk("R1 ready in reset", ready, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", ready, 1);
    chk("R2 idle no pulse", setp, 0);
  endtask

  task automatic t_basic;
    send("R2 secure g1ns", 5, 2, 0, 0, 2, 0);
    send("R3 downgrade accept", 3, 1, 0, 0, 0, 0);
    send("R3 downgrade ns acc1", 4, 1, 1, 0, 0, 1);
    send("R5 downgrade ns acc0 drop", 4, 1, 1, 0, 0, 0);
    send("R4 g0 to g1s drop", 7, 0, 0, 0, 1, 3);
    send("R4 g0 to g1ns drop", 8, 0, 0, 0, 2, 3);
    send("R4 reserved drop", 9, 3, 0, 0, 2, 3);
    send("R5 g0 ns acc0", 1, 0, 1, 0, 0, 0);
    send("R5 g0 ns acc1", 1, 0, 1, 0, 0, 1);
    send("R6 g1s ns acc1", 2, 1, 1, 0, 1, 1);
    send("R6 g1s ns acc2", 2, 1, 1, 0, 1, 2);
    send("R7 sec dis acc0", 6, 0, 1, 1, 0, 0);
    send("R9 ns to g1ns acc0", 15, 2, 1, 0, 2, 0);
    send("R9 secure g1s acc0", 0, 1, 0, 0, 1, 0);
    send("R8 id 16", 16, 2, 0, 0, 2, 0);
    send("R8 id 31", 31, 0, 0, 0, 0, 3);
  endtask

  task automatic t_sweep;
    for (int rg = 0; rg < 4; rg++)
      for (int tg = 0; tg < 4; tg++)
        for (int n = 0; n < 2; n++)
          for (int sd = 0; sd < 2; sd++)
            for (int a = 0; a < 4; a++)
              send("R7 sweep", (rg * 4 + a) % 16, rg, n[0], sd[0], tg, a);
  endtask

  task automatic t_b2b;
    @(negedge clk);
    drive(10, 2, 0, 0, 2, 0);
    @(negedge clk);
    chk("R10 first accept", setp, 1);
    chk("R10 first id", sid, 10);
    drive(11, 0, 1, 0, 0, 0);
    @(negedge clk);
    chk("R10 second drop", setp, 0);
    drive(12, 1, 1, 0, 1, 3);
    @(negedge clk);
    chk("R10 third accept", setp, 1);
    chk("R10 third id", sid, 12);
    drive(20, 2, 0, 0, 2, 0);
    @(negedge clk);
    chk("R10 fourth err", err, 1);
    chk("R8 no set on err", setp, 0);
    valid = 1'b0;
    @(negedge clk);
    chk("R2 no valid no pulse", setp, 0);
    chk("R8 err width", err, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_sweep();
    t_b2b();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule